// File: doc/BRIEF.md
# Windowed 64b/66b Block Alignment Monitor

This block finds and keeps 66-bit block alignment on a received 64b/66b stream. An upstream bit-slip stage presents one candidate 66-bit word per strobe. The block checks the two sync-header bits of each word. It counts good and bad headers inside programmable windows. From those counts it decides whether the current alignment is trustworthy.

While hunting, the block declares lock once X good headers have appeared within a window of Y examined words. If the window closes short of X, the block requests a one-bit slip and starts a new window at the next alignment. Stepping through every alignment in turn gives a worst-case acquisition of roughly 66 windows.

While locked, the block counts bad headers in consecutive windows of Z words. When W bad headers occur inside one window, lock is dropped, a slip is requested and the search restarts. Setting X equal to Y turns acquisition into a strict run of consecutive good headers. The window settings are sampled only while the block is unlocked.

Top module: `blk_lock_66`

## Requirements
- R1: A header, taken from bits [65:64] of `word_i`, is good when it equals 01 or 10; the values 00 and 11 are bad.
- R2: While `rst_ni` is low, `lock_o` and `slip_o` are 0 and all three counters read 0. The window settings reset to X=Y=64, W=16 and Z=64.
- R3: While unlocked, the edge that samples the word bringing the good count of the current window to X sets `lock_o` and clears the counters.
- R4: While unlocked, when the Y-th word of a window is sampled and fewer than X headers were good, `slip_o` is 1 for exactly one cycle and the counters clear.
- R5: With X = Y, lock needs Y consecutive good headers; a single bad header in the window forces a slip instead.
- R6: While locked, the edge that samples the W-th bad header of a window clears `lock_o`, pulses `slip_o` in the same cycle and clears the counters.
- R7: While locked, when a Z-word window closes with fewer than W bad headers, the window and bad counts clear and lock is held.
- R8: The X, Y, W and Z inputs are loaded only on edges where the block is unlocked; changes made while locked have no effect until lock is lost.
- R9: A cycle with `valid_i` low changes no counter, state or output, whatever `word_i` holds.
- R10: `win_cnt_o` shows the number of words examined in the current window. `good_cnt_o` shows the good headers seen while hunting and is 0 while locked. `bad_cnt_o` shows the bad headers seen while locked and is 0 while hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 66 | Candidate block at the current alignment; header in [65:64] |
| valid_i | input | 1 | Word strobe |
| cfg_x_i | input | CNT_W | Good headers needed for lock |
| cfg_y_i | input | CNT_W | Acquisition window length |
| cfg_w_i | input | CNT_W | Bad headers that drop lock |
| cfg_z_i | input | CNT_W | Tracking window length |
| lock_o | output | 1 | Alignment locked |
| slip_o | output | 1 | One-cycle request to shift alignment by one bit |
| win_cnt_o | output | CNT_W | Words examined in the current window |
| good_cnt_o | output | CNT_W | Good headers in the current acquisition window |
| bad_cnt_o | output | CNT_W | Bad headers in the current tracking window |

## Verification
The bench first builds small windows: X=4, Y=6, W=2 and Z=4. With these, a failed window, an early lock, a tracking window that closes clean and a loss of lock all fit into a few dozen words. It then loads X=Y=3 with W=1, which checks a strict run and a single-error loss, and shows that settings written while locked only take effect after the loss. Finally it runs X=Y=64, W=16 and Z=64 so that the 64-word consecutive acquisition is exercised at full length, including a bad 64th word.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned HDR_W = 2;
  localparam int unsigned BLK_W = 66;
  localparam int unsigned DEF_X = 64;
  localparam int unsigned DEF_Y = 64;
  localparam int unsigned DEF_W = 16;
  localparam int unsigned DEF_Z = 64;

  typedef enum logic { ST_HUNT = 1'b0, ST_LOCK = 1'b1 } align_st_e;
endpackage

// File: rtl/blk_hdr_check.sv
module blk_hdr_check #(
  parameter int unsigned HDR_W = 2
) (
  input  logic [HDR_W-1:0] hdr_i,
  output logic             ok_o
);
  // transition-bearing headers only: 01 / 10
  assign ok_o = (hdr_i == 2'b01) || (hdr_i == 2'b10);
endmodule

// File: rtl/blk_win_cnt.sv
module blk_win_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign nxt_o = cnt_q + CNT_W'(inc_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= nxt_o;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1) |-> (!inc_i || clr_i)); // R10
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import blk_lock_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          hdr_ok_i,
  input  logic [CW-1:0] cfg_x_i,
  input  logic [CW-1:0] cfg_y_i,
  input  logic [CW-1:0] cfg_w_i,
  input  logic [CW-1:0] cfg_z_i,
  input  logic [CW-1:0] win_nxt_i,
  input  logic [CW-1:0] good_nxt_i,
  input  logic [CW-1:0] bad_nxt_i,
  output logic          lock_o,
  output logic          slip_o,
  output logic          clr_o
);
  align_st_e st_q;
  logic      slip_q;
  logic [CW-1:0] x_q, y_q, w_q, z_q;
  logic acq_hit, acq_miss, trk_lost, trk_wrap;

  // window settings frozen while locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= CW'(DEF_X);
      y_q <= CW'(DEF_Y);
      w_q <= CW'(DEF_W);
      z_q <= CW'(DEF_Z);
    end else if (st_q == ST_HUNT) begin
      x_q <= cfg_x_i;
      y_q <= cfg_y_i;
      w_q <= cfg_w_i;
      z_q <= cfg_z_i;
    end
  end

  always_comb begin
    acq_hit  = (st_q == ST_HUNT) && valid_i && (good_nxt_i >= x_q);
    acq_miss = (st_q == ST_HUNT) && valid_i && !acq_hit && (win_nxt_i >= y_q);
    trk_lost = (st_q == ST_LOCK) && valid_i && (bad_nxt_i >= w_q);
    trk_wrap = (st_q == ST_LOCK) && valid_i && !trk_lost && (win_nxt_i >= z_q);
    clr_o    = acq_hit || acq_miss || trk_lost || trk_wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      slip_q <= 1'b0;
    end else begin
      slip_q <= acq_miss || trk_lost;
      unique case (st_q)
        ST_HUNT: if (acq_hit)  st_q <= ST_LOCK;
        ST_LOCK: if (trk_lost) st_q <= ST_HUNT;
        default: st_q <= ST_HUNT;
      endcase
    end
  end

  assign lock_o = (st_q == ST_LOCK);
  assign slip_o = slip_q;

  AST_LOCK_ON_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(valid_i && hdr_ok_i)); // R3
  AST_SLIP_ON_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_q |-> $past(valid_i)); // R4
  AST_LOSS_SLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> slip_q); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && $past(lock_o)) |-> ($stable(x_q) && $stable(y_q) && $stable(w_q) && $stable(z_q))); // R8
endmodule

// File: rtl/blk_lock_66.sv
module blk_lock_66
  import blk_lock_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] word_i,
  input  logic             valid_i,
  input  logic [CW-1:0]    cfg_x_i,
  input  logic [CW-1:0]    cfg_y_i,
  input  logic [CW-1:0]    cfg_w_i,
  input  logic [CW-1:0]    cfg_z_i,
  output logic             lock_o,
  output logic             slip_o,
  output logic [CW-1:0]    win_cnt_o,
  output logic [CW-1:0]    good_cnt_o,
  output logic [CW-1:0]    bad_cnt_o
);
  localparam int unsigned HDR_LSB = BLK_W - HDR_W;

  logic          hdr_ok, clr;
  logic [CW-1:0] win_nxt, good_nxt, bad_nxt;
  logic          unused_payload;

  assign unused_payload = ^word_i[HDR_LSB-1:0];

  blk_hdr_check #(.HDR_W(HDR_W)) u_hdr (
    .hdr_i (word_i[BLK_W-1:HDR_LSB]),
    .ok_o  (hdr_ok)
  );

  blk_win_cnt #(.CNT_W(CW)) u_win (
    .clk_i, .rst_ni,
    .inc_i (valid_i),
    .clr_i (clr),
    .cnt_o (win_cnt_o),
    .nxt_o (win_nxt)
  );

  blk_win_cnt #(.CNT_W(CW)) u_good (
    .clk_i, .rst_ni,
    .inc_i (valid_i && hdr_ok && !lock_o),
    .clr_i (clr),
    .cnt_o (good_cnt_o),
    .nxt_o (good_nxt)
  );

  blk_win_cnt #(.CNT_W(CW)) u_bad (
    .clk_i, .rst_ni,
    .inc_i (valid_i && !hdr_ok && lock_o),
    .clr_i (clr),
    .cnt_o (bad_cnt_o),
    .nxt_o (bad_nxt)
  );

  blk_lock_ctrl #(.CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .valid_i,
    .hdr_ok_i   (hdr_ok),
    .cfg_x_i, .cfg_y_i, .cfg_w_i, .cfg_z_i,
    .win_nxt_i  (win_nxt),
    .good_nxt_i (good_nxt),
    .bad_nxt_i  (bad_nxt),
    .lock_o     (lock_o),
    .slip_o     (slip_o),
    .clr_o      (clr)
  );

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(win_cnt_o) && $stable(lock_o) && !slip_o)); // R9
  AST_SPLIT_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o ? (good_cnt_o == '0) : (bad_cnt_o == '0)); // R10
endmodule

// File: tb/sim_blk_lock_66.sv
module sim_blk_lock_66;
  localparam int CW = 8;
  localparam int NV = 22;
  // {hdr[1:0], valid, exp_lock, exp_slip, exp_win[7:0], exp_cnt[7:0]}
  localparam logic [20:0] VEC [NV] = '{
    {2'b01,1'b1,1'b0,1'b0,8'd1,8'd1}, {2'b00,1'b1,1'b0,1'b0,8'd2,8'd1},
    {2'b10,1'b1,1'b0,1'b0,8'd3,8'd2}, {2'b11,1'b1,1'b0,1'b0,8'd4,8'd2},
    {2'b01,1'b1,1'b0,1'b0,8'd5,8'd3}, {2'b00,1'b1,1'b0,1'b1,8'd0,8'd0},
    {2'b10,1'b1,1'b0,1'b0,8'd1,8'd1}, {2'b01,1'b1,1'b0,1'b0,8'd2,8'd2},
    {2'b11,1'b0,1'b0,1'b0,8'd2,8'd2}, {2'b01,1'b1,1'b0,1'b0,8'd3,8'd3},
    {2'b10,1'b1,1'b1,1'b0,8'd0,8'd0}, {2'b11,1'b1,1'b1,1'b0,8'd1,8'd1},
    {2'b01,1'b1,1'b1,1'b0,8'd2,8'd1}, {2'b10,1'b1,1'b1,1'b0,8'd3,8'd1},
    {2'b01,1'b1,1'b1,1'b0,8'd0,8'd0}, {2'b00,1'b1,1'b1,1'b0,8'd1,8'd1},
    {2'b01,1'b1,1'b1,1'b0,8'd2,8'd1}, {2'b11,1'b1,1'b0,1'b1,8'd0,8'd0},
    {2'b01,1'b1,1'b0,1'b0,8'd1,8'd1}, {2'b10,1'b1,1'b0,1'b0,8'd2,8'd2},
    {2'b01,1'b1,1'b0,1'b0,8'd3,8'd3}, {2'b10,1'b1,1'b1,1'b0,8'd0,8'd0}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [65:0]   word_i = '0;
  logic          valid_i = 1'b0;
  logic [CW-1:0] cfg_x_i = 8'd4, cfg_y_i = 8'd6, cfg_w_i = 8'd2, cfg_z_i = 8'd4;
  logic          lock_o, slip_o;
  logic [CW-1:0] win_cnt_o, good_cnt_o, bad_cnt_o;
  int            checks = 0, failures = 0;
  int            cyc = 0;

  always #10 clk_i = ~clk_i;

  blk_lock_66 u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] hdr, input logic vld);
    @(negedge clk_i);
    word_i  = {hdr, 64'hA5C3_0F1E_7700_0000 + 64'(cyc)};
    valid_i = vld;
    @(posedge clk_i);
    #1;
  endtask

  task automatic expect_state(input string req, input bit lk, input bit sl, input int win,
                              input int good, input int bad);
    chk(lock_o == lk, {req, " lock"}, lock_o, lk);
    chk(slip_o == sl, {req, " slip"}, slip_o, sl);
    chk(win_cnt_o == win, {req, " win"}, win_cnt_o, win);
    chk(good_cnt_o == good, {req, " good"}, good_cnt_o, good);
    chk(bad_cnt_o == bad, {req, " bad"}, bad_cnt_o, bad);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 5000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 5000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #1;
    expect_state("R2 in reset", 0, 0, 0, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(2'b00, 1'b0); // cfg loads while hunting

    // table: X=4 Y=6 W=2 Z=4; covers R1 R3 R4 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      step(v[20:19], v[18]);
      expect_state($sformatf("R3/R4/R6/R7/R9/R10 row%0d", i), v[17], v[16], int'(v[15:8]),
                   v[17] ? 0 : int'(v[7:0]), v[17] ? int'(v[7:0]) : 0);
    end

    // R8: settings changed while locked are ignored
    cfg_w_i = 8'd1;
    step(2'b11, 1'b1);
    expect_state("R8 W held", 1, 0, 1, 0, 1);
    step(2'b00, 1'b1);
    expect_state("R6 loss W=2", 0, 1, 0, 0, 0);
    cfg_x_i = 8'd3; cfg_y_i = 8'd3;
    step(2'b11, 1'b0);
    expect_state("R4 slip one cycle", 0, 0, 0, 0, 0);

    // R5: X=Y=3 strict run
    step(2'b01, 1'b1);
    step(2'b10, 1'b1);
    step(2'b11, 1'b1);
    expect_state("R5 bad in run slips", 0, 1, 0, 0, 0);
    step(2'b01, 1'b1);
    step(2'b10, 1'b1);
    expect_state("R5 two good", 0, 0, 2, 2, 0);
    step(2'b01, 1'b1);
    expect_state("R5 three good lock", 1, 0, 0, 0, 0);
    // R8: W=1 now active after reload
    step(2'b00, 1'b1);
    expect_state("R8 W=1 active", 0, 1, 0, 0, 0);

    // R5: X=Y=64 full run
    cfg_x_i = 8'd64; cfg_y_i = 8'd64; cfg_w_i = 8'd16; cfg_z_i = 8'd64;
    step(2'b00, 1'b0);
    for (int i = 0; i < 63; i++) step(2'b01, 1'b1);
    expect_state("R5 63 good", 0, 0, 63, 63, 0);
    step(2'b11, 1'b1);
    expect_state("R5 64th bad slips", 0, 1, 0, 0, 0);
    for (int i = 0; i < 63; i++) step(2'b10, 1'b1);
    expect_state("R5 63 good again", 0, 0, 63, 63, 0);
    step(2'b01, 1'b1);
    expect_state("R5 64 good lock", 1, 0, 0, 0, 0);
    step(2'b11, 1'b1);
    expect_state("R1 11 counted bad", 1, 0, 1, 0, 1);

    // R2: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    expect_state("R2 async reset", 0, 0, 0, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule